// File: doc/BRIEF.md
# Three-Level Nested Vectored Interrupt Controller

This block arbitrates between ten interrupt vectors, each fed by two request sources, and presents a single request line and a vector address to a processor core. Each vector's request is the OR of its two source flags, with each flag gated by its own enable. Each vector carries a priority setting of low, high or top. The top level is open only to the first two vectors. The other vectors that ask for top are treated as high.

The block keeps a three-bit in-service record with one bit per level. When the core acknowledges a request, the bit for the granted level is set. A return strobe clears the most important bit that is set. A pending vector is offered to the core only if its level is strictly above every level in service, so work at an equal or lower level waits until the running handlers return. When several vectors are eligible together, the highest level wins. Among vectors at the same level, the vector with the smallest index, and so the lowest address, wins. Once the request line is up, the offered address is frozen until the core acknowledges it.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_addr_o` is 0x0000 and `in_service_o` is 3'b000.
- R2: Vector v requests when `src_flag_i[2v] & src_en_i[2v]` or `src_flag_i[2v+1] & src_en_i[2v+1]` is set. A flag whose enable is 0 raises nothing.
- R3: The address for vector v is 0x0003 + 8*v, which covers 0x0003 to 0x004B.
- R4: `vec_prio_i[2v+1:2v]` selects the level. 2'b00 is low (in-service bit 0). 2'b01 is high (bit 1). 2'b10 and 2'b11 are top (bit 2) for vectors 0 and 1, and high for vectors 2 to 9.
- R5: Among eligible vectors, one at a higher level is offered before any at a lower level.
- R6: Among eligible vectors at the same level, the lowest index is offered.
- R7: While `irq_o` is 0, an eligible request raises `irq_o` at the next clock edge. A request is eligible when its level is strictly above the most important in-service bit.
- R8: While `irq_o` is 1 and `ack_i` is 0, `irq_o` and `vec_addr_o` hold their values. An acknowledge clears `irq_o` at that edge.
- R9: An acknowledge while `irq_o` is 1 sets the in-service bit of the granted level. Requests at that level or below are held pending.
- R10: `reti_i` clears only the most important set in-service bit.
- R11: `ack_i` while `irq_o` is 0 changes neither `in_service_o` nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_flag_i | input | 20 | Source request flags, two per vector |
| src_en_i | input | 20 | Enable for each source flag |
| vec_prio_i | input | 20 | Two-bit level setting per vector |
| ack_i | input | 1 | Core accepts the offered vector |
| reti_i | input | 1 | Handler return strobe |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 16 | Address of the offered vector |
| in_service_o | output | 3 | In-service record: bit 2 top, bit 1 high, bit 0 low |

## Verification
A request that is eligible shows on `irq_o` and `vec_addr_o` one edge after it reaches the inputs. An acknowledge clears `irq_o` and updates `in_service_o` at the same edge. After a return, a request that had been waiting needs two edges: one to clear the in-service bit and one to load the output register. The bench drives its inputs on falling edges and counts these edges before it reads outputs on a later falling edge. It also reads at intermediate edges to show that held requests stay low.

// File: rtl/irq_nest_pkg.sv
// Shared level encoding and helpers for the nested interrupt controller.
// Assumes exactly three levels: bit 0 low, bit 1 high, bit 2 top.
package irq_nest_pkg;
    localparam int unsigned LVL_N = 3;
    typedef logic [LVL_N-1:0] lvl_oh_t;

    // Keep only the most important bit that is set.
    function automatic lvl_oh_t top_level(input lvl_oh_t s);
        lvl_oh_t r;
        r = '0;
        if (s[2])      r = 3'b100;
        else if (s[1]) r = 3'b010;
        else if (s[0]) r = 3'b001;
        return r;
    endfunction
endpackage

// File: rtl/irq_src_merge.sv
// Merges the enabled source flags of each vector into one vector request.
// Assumes sources are grouped: vector v owns sources v*SRC_PER_VEC and up.
module irq_src_merge #(
    parameter int unsigned NUM_VEC     = 10,
    parameter int unsigned SRC_PER_VEC = 2
) (
    input  logic [NUM_VEC*SRC_PER_VEC-1:0] flag_i,
    input  logic [NUM_VEC*SRC_PER_VEC-1:0] en_i,
    output logic [NUM_VEC-1:0]             vreq_o
);
    // One OR tree per vector over its gated sources.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign vreq_o[v] = |(flag_i[v*SRC_PER_VEC +: SRC_PER_VEC] &
                             en_i[v*SRC_PER_VEC +: SRC_PER_VEC]);
    end
endmodule

// File: rtl/irq_prio_decode.sv
// Turns each vector's two-bit level setting into a one-hot level.
// Assumes only the first TOP_VECS vectors may reach the top level; others
// asking for it are demoted to high.
module irq_prio_decode
    import irq_nest_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 10,
    parameter int unsigned TOP_VECS = 2
) (
    input  logic [2*NUM_VEC-1:0]        prio_i,
    output logic [NUM_VEC-1:0][LVL_N-1:0] lvl_o
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        if (v < TOP_VECS) begin : g_top
            // Full three-way decode for vectors allowed at top level.
            assign lvl_o[v] = prio_i[2*v+1] ? 3'b100 :
                              prio_i[2*v]   ? 3'b010 : 3'b001;
        end else begin : g_clamp
            // Any non-zero setting maps to high.
            assign lvl_o[v] = (|prio_i[2*v +: 2]) ? 3'b010 : 3'b001;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Picks the winning vector among eligible requests: highest level first,
// then lowest index. A level is eligible only if no in-service bit at or
// above it is set. Purely combinational.
module irq_arbiter
    import irq_nest_pkg::*;
#(
    parameter int unsigned NUM_VEC = 10,
    localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]            vreq_i,
    input  logic [NUM_VEC-1:0][LVL_N-1:0] lvl_i,
    input  lvl_oh_t                       isr_i,
    output logic                          win_valid_o,
    output logic [IDX_W-1:0]              win_idx_o,
    output lvl_oh_t                       win_lvl_o
);
    lvl_oh_t hit;
    lvl_oh_t elig;

    // Collect per-level requests and pick the best eligible level.
    always_comb begin
        hit  = '0;
        elig = '0;
        win_lvl_o = '0;
        for (int l = 0; l < LVL_N; l++) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                hit[l] = hit[l] | (vreq_i[v] & lvl_i[v][l]);
            end
            elig[l] = ((isr_i >> l) == '0);
        end
        for (int l = 0; l < LVL_N; l++) begin
            if (hit[l] && elig[l]) win_lvl_o = lvl_oh_t'(1) << l;
        end
    end

    // Lowest index at the chosen level; descending scan so the last hit wins.
    always_comb begin
        win_idx_o = '0;
        for (int v = NUM_VEC-1; v >= 0; v--) begin
            if (vreq_i[v] && |(lvl_i[v] & win_lvl_o)) win_idx_o = IDX_W'(v);
        end
        win_valid_o = |win_lvl_o;
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
// Three-level nested vectored interrupt controller, top level.
// Holds the offered vector in an output register until acknowledge and keeps
// a one-hot-per-level in-service record. Assumes the core clears source
// flags and that ack_i is only meaningful while irq_o is high.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned NUM_VEC     = 10,
    parameter int unsigned SRC_PER_VEC = 2,
    parameter int unsigned TOP_VECS    = 2,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned VEC_BASE    = 3,
    parameter int unsigned VEC_STEP    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_flag_i,
    input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_en_i,
    input  logic [2*NUM_VEC-1:0]          vec_prio_i,
    input  logic                          ack_i,
    input  logic                          reti_i,
    output logic                          irq_o,
    output logic [ADDR_W-1:0]             vec_addr_o,
    output logic [LVL_N-1:0]              in_service_o
);
    localparam int unsigned IDX_W = $clog2(NUM_VEC);

    logic [NUM_VEC-1:0]            vreq;
    logic [NUM_VEC-1:0][LVL_N-1:0] lvl;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    lvl_oh_t                       win_lvl;
    logic                          irq_q;
    logic [ADDR_W-1:0]             addr_q;
    lvl_oh_t                       glvl_q;
    lvl_oh_t                       isr_q;
    logic                          take;

    irq_src_merge #(.NUM_VEC(NUM_VEC), .SRC_PER_VEC(SRC_PER_VEC)) merge_i (
        .flag_i (src_flag_i),
        .en_i   (src_en_i),
        .vreq_o (vreq)
    );

    irq_prio_decode #(.NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS)) decode_i (
        .prio_i (vec_prio_i),
        .lvl_o  (lvl)
    );

    irq_arbiter #(.NUM_VEC(NUM_VEC)) arb_i (
        .vreq_i      (vreq),
        .lvl_i       (lvl),
        .isr_i       (isr_q),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    assign take = irq_q & ack_i;

    // Output register: load a winner when idle, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            addr_q <= '0;
            glvl_q <= '0;
        end else if (irq_q) begin
            if (ack_i) irq_q <= 1'b0;
        end else if (win_valid) begin
            irq_q  <= 1'b1;
            addr_q <= ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);
            glvl_q <= win_lvl;
        end
    end

    // In-service record: return clears the top set bit, acknowledge adds one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (reti_i ? (isr_q & ~top_level(isr_q)) : isr_q) |
                     (take ? glvl_q : lvl_oh_t'(0));
        end
    end

    assign irq_o        = irq_q;
    assign vec_addr_o   = addr_q;
    assign in_service_o = isr_q;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
// Port-level property checker for irq_nest_ctrl, bound to every instance.
// Assumes the default address grid (base plus a fixed step per vector).
module irq_nest_ctrl_chk #(
    parameter int unsigned NUM_VEC  = 10,
    parameter int unsigned TOP_VECS = 2,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              reti_i,
    input logic              irq_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [2:0]        in_service_o
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(VEC_BASE + (NUM_VEC-1)*VEC_STEP);
    localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'(VEC_BASE + (TOP_VECS-1)*VEC_STEP);
    localparam logic [ADDR_W-1:0] A_STEP  = ADDR_W'(VEC_STEP);

    // R1: reset empties the request and the in-service record.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && in_service_o == 3'b000));

    // R3: an offered address lies on the vector grid.
    a_r3_addr_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_addr_o >= A_FIRST && vec_addr_o <= A_LAST &&
                   ((vec_addr_o - A_FIRST) % A_STEP) == '0));

    // R4: only the first vectors can enter the top level.
    a_r4_top_only_first: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i && !in_service_o[2]) |=>
            (!in_service_o[2] || $past(vec_addr_o) <= A_TOP));

    // R8: offered vector is held while unacknowledged.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_addr_o)));

    // R8: acknowledge drops the request.
    a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R9: the record never grows without an acknowledge.
    a_r9_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ($countones(in_service_o) <= $countones($past(in_service_o))));

    // R10: a return removes exactly one in-service bit.
    a_r10_reti_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(irq_o && ack_i) && in_service_o != 3'b000) |=>
            ($countones(in_service_o) + 1 == $countones($past(in_service_o))));

    // R11: an acknowledge with nothing offered leaves the record alone.
    a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ack_i && !reti_i) |=> $stable(in_service_o));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
    .NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .irq_o        (irq_o),
    .vec_addr_o   (vec_addr_o),
    .in_service_o (in_service_o)
);

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for irq_nest_ctrl: one task per scenario, inputs driven and
// outputs read on falling edges.
module irq_nest_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src_flag = '0;
    logic [19:0] src_en = '1;
    logic [19:0] vec_prio = '0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq;
    logic [15:0] vaddr;
    logic [2:0]  isr;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_nest_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_flag_i(src_flag), .src_en_i(src_en),
        .vec_prio_i(vec_prio), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_addr_o(vaddr), .in_service_o(isr)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int v);
        return 16'(3 + 8*v);
    endfunction

    task automatic ack_clear(input int src);
        ack = 1'b1;
        src_flag[src] = 1'b0;
        step();
        ack = 1'b0;
    endtask

    task automatic reti_pulse();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    // R1: reset state after power-up
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "addr", 32'(vaddr), 0);
        chk("R1", "isr", 32'(isr), 0);
    endtask

    // R2, R3: source gating and address of vector 3
    task automatic t_merge();
        src_en[7] = 1'b0;
        src_flag[7] = 1'b1;
        step(); step();
        chk("R2", "masked irq", 32'(irq), 0);
        src_en[7] = 1'b1;
        step();
        chk("R2", "irq", 32'(irq), 1);
        chk("R3", "addr", 32'(vaddr), 32'(addr_of(3)));
        ack_clear(7);
        chk("R8", "irq after ack", 32'(irq), 0);
        chk("R9", "isr low", 32'(isr), 3'b001);
        reti_pulse();
        chk("R10", "isr", 32'(isr), 0);
    endtask

    // R6, R7, R9: same-level tie and held pending request
    task automatic t_tie();
        src_flag[10] = 1'b1;
        src_flag[17] = 1'b1;
        step();
        chk("R6", "addr", 32'(vaddr), 32'(addr_of(5)));
        ack_clear(10);
        chk("R9", "isr", 32'(isr), 3'b001);
        step(); step();
        chk("R9", "held irq", 32'(irq), 0);
        reti_pulse();
        chk("R7", "irq at reti edge", 32'(irq), 0);
        step();
        chk("R7", "irq", 32'(irq), 1);
        chk("R7", "addr", 32'(vaddr), 32'(addr_of(8)));
        ack_clear(17);
        reti_pulse();
    endtask

    // R5, R7, R9, R10: level order and nesting
    task automatic t_level();
        vec_prio[9:8] = 2'b01;
        src_flag[18] = 1'b1;
        src_flag[9] = 1'b1;
        step();
        chk("R5", "addr", 32'(vaddr), 32'(addr_of(4)));
        ack_clear(9);
        chk("R9", "isr", 32'(isr), 3'b010);
        vec_prio[1:0] = 2'b10;
        src_flag[0] = 1'b1;
        step();
        chk("R7", "nested irq", 32'(irq), 1);
        chk("R7", "nested addr", 32'(vaddr), 32'(addr_of(0)));
        ack_clear(0);
        chk("R9", "isr", 32'(isr), 3'b110);
        reti_pulse();
        chk("R10", "isr", 32'(isr), 3'b010);
        step();
        chk("R9", "low held", 32'(irq), 0);
        reti_pulse();
        chk("R10", "isr", 32'(isr), 0);
        step();
        chk("R7", "addr", 32'(vaddr), 32'(addr_of(9)));
        ack_clear(18);
        reti_pulse();
        vec_prio = '0;
    endtask

    // R4: demotion of top setting and codes 10/11
    task automatic t_clamp();
        vec_prio[13:12] = 2'b10;
        vec_prio[5:4]   = 2'b01;
        src_flag[12] = 1'b1;
        src_flag[4]  = 1'b1;
        step();
        chk("R4", "demoted addr", 32'(vaddr), 32'(addr_of(2)));
        ack_clear(4);
        reti_pulse();
        step();
        chk("R4", "addr", 32'(vaddr), 32'(addr_of(6)));
        ack_clear(12);
        chk("R4", "demoted isr", 32'(isr), 3'b010);
        reti_pulse();
        vec_prio = '0;
        vec_prio[3:2] = 2'b11;
        vec_prio[1:0] = 2'b01;
        src_flag[2] = 1'b1;
        src_flag[1] = 1'b1;
        step();
        chk("R4", "code 11 addr", 32'(vaddr), 32'(addr_of(1)));
        ack_clear(2);
        chk("R4", "code 11 isr", 32'(isr), 3'b100);
        reti_pulse();
        step();
        ack_clear(1);
        chk("R4", "code 01 isr", 32'(isr), 3'b010);
        reti_pulse();
        vec_prio = '0;
    endtask

    // R8, R7, R10: offered vector frozen until acknowledge
    task automatic t_stable();
        src_flag[15] = 1'b1;
        step();
        chk("R8", "addr", 32'(vaddr), 32'(addr_of(7)));
        vec_prio[1:0] = 2'b10;
        src_flag[0] = 1'b1;
        step(); step();
        chk("R8", "held irq", 32'(irq), 1);
        chk("R8", "held addr", 32'(vaddr), 32'(addr_of(7)));
        ack_clear(15);
        chk("R8", "irq", 32'(irq), 0);
        step();
        chk("R7", "preempt addr", 32'(vaddr), 32'(addr_of(0)));
        ack_clear(0);
        chk("R9", "isr", 32'(isr), 3'b101);
        reti_pulse();
        chk("R10", "isr", 32'(isr), 3'b001);
        reti_pulse();
        chk("R10", "isr", 32'(isr), 0);
        vec_prio = '0;
    endtask

    // R11: acknowledge with no request offered
    task automatic t_idle_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
        step();
        chk("R11", "isr", 32'(isr), 0);
        chk("R11", "irq", 32'(irq), 0);
    endtask

    // R1: synchronous reset empties a busy record
    task automatic t_reset_mid();
        src_flag[6] = 1'b1;
        step();
        ack_clear(6);
        chk("R1", "pre-reset isr", 32'(isr), 3'b001);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R1", "isr", 32'(isr), 0);
        chk("R1", "irq", 32'(irq), 0);
    endtask

    initial begin
        t_reset();
        t_merge();
        t_tie();
        t_level();
        t_clamp();
        t_stable();
        t_idle_ack();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule